// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a small-depth, synthesizable model of a synchronous burst static RAM. Its word is 36 bits wide, split into four 9-bit lanes. Each lane holds eight data bits and one parity bit. Address, write data, chip enables, write controls and burst controls are all captured on the rising clock edge. The read word is not registered again on its way out: it comes straight from the array at the current burst address. An asynchronous output-enable input gates the drive indication for that word.

Two address strobes can start an access, and they follow different rules. The processor strobe only acts while the primary chip enable is asserted, and it always reads. The controller strobe either reads or writes, and when the primary chip enable is deasserted it deselects the device instead. After a load, a two-bit counter steps through the other three words of the aligned group of four, in interleaved or linear order. A snooze input freezes the device and keeps the array contents. The output is a plain word with a separate drive indication. A memory port has no back-pressure, so no valid/ready handshake is used: every access completes in the cycle it is issued.

Top module: `fts_burst_ram`

## Requirements
- R1: With `ce_n` low, a low `adsp_n` loads `addr` and performs a read. It does so regardless of `gw_n`, `bwe_n`, `bw_n` and `adsc_n`, and it takes precedence over `adsc_n`.
- R2: With `ce_n` high, `adsp_n` is ignored. If `adsc_n` is also high, the edge is treated as a burst continuation.
- R3: A low `adsc_n` that is not overridden by R1 works as follows. With `ce_n` low it loads `addr` and reads or writes as R6 decides. With `ce_n` high it deselects the device, and `dq_oe` goes low after that edge.
- R4: A load made while `ce2` is low or `ce2_n` is high leaves the device deselected, so `dq_oe` stays low.
- R5: Chip enables are sampled only on load edges. A continuation edge keeps the current selection whatever `ce_n`, `ce2` and `ce2_n` are doing.
- R6: Lane k is bits [9k+8:9k], and its parity bit is 9k+8. Lanes are written as follows:
  - A low `gw_n` writes all four lanes.
  - Otherwise, a high `bwe_n` means a read.
  - Otherwise, lane k is written only when `bw_n[k]` is low, and all four `bw_n` bits high means a read.
  - A write cycle leaves `dq_oe` low.
- R7: The two low address bits of the burst depend on `burst_lin`. With `burst_lin` low (interleaved), they are the loaded bits XOR the beat count. With `burst_lin` high (linear), they are the loaded bits plus the beat count, modulo 4. A low `adv_n` on a continuation edge advances the count, and a high `adv_n` holds it.
- R8: On a continuation edge with write controls active, the write goes to the burst address after the advance decision. With `adv_n` high, that is the word already addressed. A deselected device writes nothing.
- R9: `rdata` shows the array word at the current burst address in the cycle right after the loading or advancing edge. `dq_oe` follows `oe_n` without waiting for a clock, and is high only while `oe_n` is low, the device is selected, the last edge was a read, and `snooze` is low.
- R10: While `snooze` is high, `dq_oe` is low and every other input is ignored. When `snooze` falls, the address, selection and array contents are unchanged.
- R11: After reset the device is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Tertiary chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 36 | Write word, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Standby freeze, active high |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | 36 | Flow-through read word |
| dq_oe | output | 1 | Drive indication for rdata |

## Verification
A wrong burst count or base address shows up as the wrong `rdata` word in the very next cycle, because no output register stands in between. A wrong selection flag or write flag shows up as a wrong `dq_oe` level in the cycle after the edge. A misdecoded lane mask stays hidden until the damaged word is read back, which the stimulus does one cycle after each write. Snooze and deselect leaks are exposed by reading, right after release, the exact word that an ignored write would have changed.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BEAT_W = 2;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_CONT  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_DESEL = 2'd2,
    OP_FROZE = 2'd3
  } edge_op_e;
endpackage

// File: rtl/fts_lane_dec.sv
module fts_lane_dec
  import fts_pkg::*;
(
  input  logic       gw_n,
  input  logic       bwe_n,
  input  lane_mask_t bw_n,
  output lane_mask_t lane_we
);
  always_comb begin
    if (!gw_n)      lane_we = '1;
    else if (bwe_n) lane_we = '0;
    else            lane_we = ~bw_n;
  end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
  import fts_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  input  logic          lin,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] cnt_nxt;

  function automatic logic [BEAT_W-1:0] beat_ofs(input logic [BEAT_W-1:0] b,
                                                  input logic [BEAT_W-1:0] c,
                                                  input logic l);
    return l ? (b + c) : (b ^ c);
  endfunction

  assign cnt_nxt  = step ? cnt_q + 1'b1 : cnt_q;
  assign cur_addr = {base_q[AW-1:BEAT_W], beat_ofs(base_q[BEAT_W-1:0], cnt_q, lin)};
  assign nxt_addr = load ? load_addr
                  : {base_q[AW-1:BEAT_W], beat_ofs(base_q[BEAT_W-1:0], cnt_nxt, lin)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_addr;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/fts_array.sv
module fts_array
  import fts_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  lane_mask_t    we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
  import fts_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          adsp_n,
  input  logic          adsc_n,
  input  logic          adv_n,
  input  logic          ce_n,
  input  logic          ce2,
  input  logic          ce2_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [3:0]    bw_n,
  input  logic [35:0]   wdata,
  input  logic          oe_n,
  input  logic          snooze,
  input  logic          burst_lin,
  output logic [35:0]   rdata,
  output logic          dq_oe
);
  edge_op_e   op;
  logic       p_take;
  logic       sel_q, wr_q;
  logic       sel_nxt;
  logic       load, step;
  lane_mask_t dec_we, arr_we;
  logic [AW-1:0] cur_addr, nxt_addr;

  assign p_take = !adsp_n && !ce_n;

  always_comb begin
    if (snooze)                 op = OP_FROZE;
    else if (p_take)            op = OP_LOAD;
    else if (!adsc_n && ce_n)   op = OP_DESEL;
    else if (!adsc_n)           op = OP_LOAD;
    else                        op = OP_CONT;
  end

  assign load = (op == OP_LOAD);
  assign step = (op == OP_CONT) && !adv_n && sel_q;

  always_comb begin
    case (op)
      OP_LOAD:  sel_nxt = ce2 && !ce2_n;
      OP_DESEL: sel_nxt = 1'b0;
      default:  sel_nxt = sel_q;
    endcase
  end

  fts_lane_dec u_dec (
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .lane_we (dec_we)
  );

  always_comb begin
    arr_we = dec_we;
    if (op == OP_FROZE || op == OP_DESEL || !sel_nxt) arr_we = '0;
    if (op == OP_LOAD && p_take)                      arr_we = '0;
  end

  fts_burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_addr (addr),
    .step      (step),
    .lin       (burst_lin),
    .cur_addr  (cur_addr),
    .nxt_addr  (nxt_addr)
  );

  fts_array #(.DEPTH(DEPTH)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (nxt_addr),
    .wdata (wdata),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (op != OP_FROZE) begin
      sel_q <= sel_nxt;
      wr_q  <= |arr_we;
    end
  end

  assign dq_oe = !oe_n && sel_q && !wr_q && !snooze;
endmodule

// File: rtl/fts_chk.sv
module fts_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adsp_n,
  input logic        adsc_n,
  input logic        ce_n,
  input logic        ce2,
  input logic        gw_n,
  input logic        oe_n,
  input logic        snooze,
  input logic [35:0] rdata,
  input logic        dq_oe
);
  // R10
  snooze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |-> !dq_oe);

  // R10
  snooze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> $stable(rdata));

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  // R3
  adsc_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !adsc_n && ce_n) |=> !dq_oe);

  // R4
  ce2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !adsc_n && !ce2 && (adsp_n || ce_n)) |=> !dq_oe);

  // R6
  gw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && adsp_n && !adsc_n && !ce_n && !gw_n) |=> !dq_oe);
endmodule

bind fts_burst_ram fts_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .adsp_n (adsp_n),
  .adsc_n (adsc_n),
  .ce_n   (ce_n),
  .ce2    (ce2),
  .gw_n   (gw_n),
  .oe_n   (oe_n),
  .snooze (snooze),
  .rdata  (rdata),
  .dq_oe  (dq_oe)
);

// File: tb/sim_fts_burst_ram.sv
module sim_fts_burst_ram;
  localparam int PER = 10;
  localparam int AW  = 6;

  typedef struct packed {
    logic lin; logic p; logic c; logic v; logic ce; logic c2; logic c2n;
    logic gw; logic bwe; logic [3:0] bw; logic [5:0] a; logic [35:0] wd;
    logic eoe; logic [35:0] ed; logic [3:0] rq;
  } vec_t;

  localparam int NV = 34;
  // fields: lin p c v ce ce2 ce2n gw bwe bw addr wdata exp_oe exp_data req
  localparam vec_t VT [NV] = '{
    '{0,1,0,1,0,1,0,0,1,4'hF,6'd4,36'h111111111,0,36'h0,4'd6},          // R6 global write
    '{0,1,0,1,0,1,0,0,1,4'hF,6'd5,36'h222222222,0,36'h0,4'd3},          // R3
    '{0,1,0,1,0,1,0,0,1,4'hF,6'd6,36'h333333333,0,36'h0,4'd3},
    '{0,1,0,1,0,1,0,0,1,4'hF,6'd7,36'h444444444,0,36'h0,4'd3},
    '{0,1,0,1,0,1,0,1,1,4'hF,6'd4,36'h0,1,36'h111111111,4'd3},          // R3 read
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h222222222,4'd7},          // R7 interleaved
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h333333333,4'd7},
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h444444444,4'd7},
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h111111111,4'd7},
    '{0,0,1,1,0,1,0,1,1,4'hF,6'd5,36'h0,1,36'h222222222,4'd1},          // R1
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h111111111,4'd7},
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h444444444,4'd7},
    '{0,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h333333333,4'd7},
    '{1,1,0,1,0,1,0,1,1,4'hF,6'd6,36'h0,1,36'h333333333,4'd3},
    '{1,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h444444444,4'd7},          // R7 linear
    '{1,1,1,0,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h111111111,4'd7},
    '{1,1,1,1,0,1,0,1,1,4'hF,6'd0,36'h0,1,36'h111111111,4'd7},          // R7 hold
    '{0,1,0,1,0,1,0,1,0,4'hE,6'd4,36'hFFFFFFFFF,0,36'h0,4'd6},          // R6 lane 0
    '{0,1,0,1,0,1,0,1,1,4'hF,6'd4,36'h0,1,36'h1111111FF,4'd6},
    '{0,1,0,1,0,1,0,0,1,4'hF,6'd5,36'h5AAAAAAAA,0,36'h0,4'd6},          // R6 override
    '{0,1,0,1,0,1,0,1,1,4'hF,6'd5,36'h0,1,36'h5AAAAAAAA,4'd6},
    '{0,1,0,1,0,1,0,1,0,4'hF,6'd6,36'h0,1,36'h333333333,4'd6},          // R6 no lane
    '{0,0,0,1,0,1,0,0,1,4'hF,6'd7,36'h0,1,36'h444444444,4'd1},          // R1 precedence
    '{0,1,1,1,0,1,0,0,1,4'hF,6'd0,36'h777777777,0,36'h0,4'd8},          // R8
    '{0,1,0,1,0,1,0,1,1,4'hF,6'd7,36'h0,1,36'h777777777,4'd8},
    '{0,0,1,1,1,1,0,1,1,4'hF,6'd4,36'h0,1,36'h777777777,4'd2},          // R2
    '{0,1,0,1,1,1,0,1,1,4'hF,6'd4,36'h0,0,36'h0,4'd3},                  // R3 deselect
    '{0,1,1,1,0,1,0,0,1,4'hF,6'd0,36'h0,0,36'h0,4'd8},
    '{0,1,0,1,0,1,0,1,1,4'hF,6'd7,36'h0,1,36'h777777777,4'd8},
    '{0,1,0,1,0,0,0,1,1,4'hF,6'd4,36'h0,0,36'h0,4'd4},                  // R4
    '{0,1,0,1,0,1,1,1,1,4'hF,6'd4,36'h0,0,36'h0,4'd4},
    '{0,0,1,1,0,0,0,1,1,4'hF,6'd4,36'h0,0,36'h0,4'd4},
    '{1,1,0,1,0,1,0,1,1,4'hF,6'd5,36'h0,1,36'h5AAAAAAAA,4'd5},
    '{1,1,1,0,1,0,1,1,1,4'hF,6'd0,36'h0,1,36'h333333333,4'd5}           // R5
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, ce_n = 0, ce2 = 1, ce2_n = 0;
  logic gw_n = 1, bwe_n = 1, oe_n = 0, snooze = 0, burst_lin = 0;
  logic [3:0]  bw_n = 4'hF;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        dq_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  fts_burst_ram #(.DEPTH(64)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n), .snooze(snooze),
    .burst_lin(burst_lin), .rdata(rdata), .dq_oe(dq_oe)
  );

  task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 0; ce2 = 1; ce2_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; wdata = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset dq_oe", {35'd0, dq_oe}, 36'd0);

    for (int i = 0; i < NV; i++) begin
      burst_lin = VT[i].lin; adsp_n = VT[i].p; adsc_n = VT[i].c; adv_n = VT[i].v;
      ce_n = VT[i].ce; ce2 = VT[i].c2; ce2_n = VT[i].c2n; gw_n = VT[i].gw;
      bwe_n = VT[i].bwe; bw_n = VT[i].bw; addr = VT[i].a; wdata = VT[i].wd;
      @(posedge clk);
      #(PER/4);
      chk($sformatf("R%0d vec %0d oe", VT[i].rq, i), {35'd0, dq_oe}, {35'd0, VT[i].eoe});
      if (VT[i].eoe)
        chk($sformatf("R%0d vec %0d data", VT[i].rq, i), rdata, VT[i].ed);
      @(negedge clk);
    end

    // R10 snooze: output off at once, ignored write to the addressed word
    idle();
    burst_lin = 1;
    snooze = 1;
    #1 chk("R10 snooze dq_oe", {35'd0, dq_oe}, 36'd0);
    adsc_n = 0; gw_n = 0; addr = 6'd6; wdata = 36'h0;
    @(posedge clk);
    @(negedge clk);
    idle();
    snooze = 0;
    #1 chk("R10 release dq_oe", {35'd0, dq_oe}, 36'd1);
    chk("R10 contents kept", rdata, 36'h333333333);

    // R9 asynchronous output enable
    oe_n = 1;
    #1 chk("R9 oe_n high", {35'd0, dq_oe}, 36'd0);
    oe_n = 0;
    #1 chk("R9 oe_n low", {35'd0, dq_oe}, 36'd1);
    chk("R9 flow data", rdata, 36'h333333333);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule